// File: doc/BRIEF.md
# Selectable Small-Ratio Clock Prescaler

This block derives a slower clock from a fast input clock. A 3-bit select field picks one of eight behaviours: integer division by 2, 3, 4, 5 or 6, a pass-through in which the output copies the input clock, or a quiet output that holds still. A separate power-down input silences the block whatever the select field says. The select and power-down pins are expected to come from a register file running on the same fast clock. They are plain level controls with no handshake.

The divided output comes from a register, and every divided period begins with a high phase. A new selection never cuts a period short. While a divided period is running, the new code is taken in only at the edge that would raise the output again. When the output is quiet or passing the clock through, the new code is taken in at the next input rising edge.

Top module: `clk_prescaler`

## Requirements
- R1: While reset is asserted the output is low and the period counter is cleared. At the first input rising edge after reset is released, with the select at its reset value 000, the output starts a divide-by-2 period with its high phase.
- R2: Select code 000 divides by 2: the output is high for one input cycle and then low for one input cycle.
- R3: Select codes 001, 010, 011 and 100 give periods of exactly 3, 4, 5 and 6 input cycles respectively.
- R4: In a divided period of N input cycles the output is high for the first floor(N/2) cycles and low for the remaining cycles. Each output rise coincides with an input rising edge.
- R5: Select code 110 passes the input clock straight through: the output is high while the input clock is high and low while it is low.
- R6: Select codes 101 and 111 hold the output low.
- R7: With the power-down input at 1 the output is low from the first input rising edge that samples it, for any select code. With it at 0 the block runs normally.
- R8: A select change made while a divided period is running does not alter that period. The new code governs the output starting at the next output rise.
- R9: After the output has been low because of a static code or power-down, or has been passing the clock through, a new divide code takes effect at the next input rising edge, and the output starts with its high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | 3 | Ratio / mode select code |
| pwr_down_i | input | 1 | 1 stops the block and forces the output low |
| clk_o | output | 1 | Divided, passed-through or static output clock |

## Verification
Any fault in the period counter or in the latched ratio appears at the output as a high or low phase of the wrong length. It shows within one output period, which is at most six input cycles. A ratio latched at the wrong moment shows up as a truncated or stretched period next to the select change, so the bench changes the code in the middle of a period as well as at period boundaries. A wrongly decoded mode, whether a stuck static state or a missed pass-through, is visible in the first input cycle after the code is taken in. The bench samples the output in both halves of every input cycle so that pass-through can be told apart from a steady level.

// File: rtl/prescale_pkg.sv
`timescale 1ns/1ps
package prescale_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MIN_RATIO = 2;
  localparam int unsigned MAX_RATIO = 6;
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);

  // Codes 0 .. LAST_DIV select ratios MIN_RATIO upward, one step per code.
  localparam logic [SEL_W-1:0] SEL_LAST_DIV = SEL_W'(MAX_RATIO - MIN_RATIO);
  localparam logic [SEL_W-1:0] SEL_PASS     = SEL_W'(6);

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_DIV  = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e              mode;
    logic [RATIO_W-1:0] ratio;
  } cfg_t;
endpackage

// File: rtl/prescale_decode.sv
`timescale 1ns/1ps
module prescale_decode
  import prescale_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output cfg_t             cfg_o
);

  always_comb begin
    cfg_o.mode  = MODE_HOLD;
    cfg_o.ratio = RATIO_W'(MIN_RATIO);
    if (sel_i <= SEL_LAST_DIV) begin
      cfg_o.mode  = MODE_DIV;
      cfg_o.ratio = RATIO_W'(sel_i) + RATIO_W'(MIN_RATIO);
    end else if (sel_i == SEL_PASS) begin
      cfg_o.mode  = MODE_PASS;
      cfg_o.ratio = RATIO_W'(1);
    end
  end

  // R3: every divide code maps into the supported ratio window
  always_comb begin
    if (cfg_o.mode == MODE_DIV) begin
      assert_ratio_range_R3: assert (cfg_o.ratio >= RATIO_W'(MIN_RATIO) &&
                                     cfg_o.ratio <= RATIO_W'(MAX_RATIO));
    end
  end

endmodule

// File: rtl/prescale_phase.sv
`timescale 1ns/1ps
module prescale_phase
  import prescale_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  cfg_t cfg_i,
  output logic div_o,
  output logic pass_o
);

  mode_e              mode_q, mode_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d, cnt_inc, high_len;
  logic               lvl_q, lvl_d;
  logic               wrap, load;

  assign cnt_inc  = cnt_q + RATIO_W'(1);
  assign high_len = ratio_q >> 1;
  assign wrap     = (mode_q == MODE_DIV) && (cnt_inc == ratio_q);
  // A new configuration is accepted only where an output rise would occur.
  assign load     = (mode_q != MODE_DIV) || wrap;

  always_comb begin
    mode_d  = mode_q;
    ratio_d = ratio_q;
    cnt_d   = cnt_inc;
    lvl_d   = (cnt_inc < high_len);
    if (pd_i) begin
      mode_d = MODE_HOLD;
      cnt_d  = '0;
      lvl_d  = 1'b0;
    end else if (load) begin
      mode_d  = cfg_i.mode;
      ratio_d = cfg_i.ratio;
      cnt_d   = '0;
      lvl_d   = (cfg_i.mode == MODE_DIV);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_HOLD;
      ratio_q <= RATIO_W'(MIN_RATIO);
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      lvl_q   <= lvl_d;
    end
  end

  assign div_o  = lvl_q;
  assign pass_o = (mode_q == MODE_PASS);

  assert_pd_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!lvl_q && mode_q == MODE_HOLD));

  assert_hold_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HOLD) |-> !lvl_q);

  assert_cfg_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DIV && !pd_i && !wrap) |=> ($stable(ratio_q) && mode_q == MODE_DIV));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DIV) |-> (cnt_q < ratio_q));

  assert_rise_at_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_q) |-> (cnt_q == '0));

  assert_high_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lvl_q) && mode_q == MODE_DIV) |-> (cnt_q == high_len));

endmodule

// File: rtl/prescale_outmux.sv
`timescale 1ns/1ps
module prescale_outmux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_i,
  input  logic div_i,
  output logic clk_o
);

  assign clk_o = pass_i ? clk_i : div_i;

  // R5: just before a falling input edge the passed-through output is high
  assert_pass_tracks_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pass_i |-> clk_o);

endmodule

// File: rtl/clk_prescaler.sv
`timescale 1ns/1ps
module clk_prescaler
  import prescale_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             pwr_down_i,
  output logic             clk_o
);

  cfg_t cfg;
  logic div_lvl;
  logic pass_en;

  prescale_decode u_decode (
    .sel_i (ratio_sel_i),
    .cfg_o (cfg)
  );

  prescale_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pwr_down_i),
    .cfg_i  (cfg),
    .div_o  (div_lvl),
    .pass_o (pass_en)
  );

  prescale_outmux u_outmux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pass_i (pass_en),
    .div_i  (div_lvl),
    .clk_o  (clk_o)
  );

  // R1: right after reset is released the output is either still low or
  // beginning a fresh period
  assert_reset_exit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_lvl) |-> !pass_en);

endmodule

// File: tb/test_clk_prescaler.sv
`timescale 1ns/1ps
module test_clk_prescaler;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd    = 1'b0;
  logic [2:0] sel   = 3'b000;
  logic       clk_o;

  typedef struct {
    logic [1:0] lvl;   // {sample in high half, sample in low half}
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;

  clk_prescaler i_clk_prescaler (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ratio_sel_i (sel),
    .pwr_down_i  (pd),
    .clk_o       (clk_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic push(input logic [1:0] lvl, input string tag);
    exp_t e;
    e.lvl = lvl;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_rep(input logic [1:0] lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) push(lvl, tag);
  endtask

  // High for floor(n/2) cycles, low for the rest (R4)
  task automatic push_div(input int n, input int periods, input string tag);
    for (int p = 0; p < periods; p++)
      for (int c = 0; c < n; c++)
        push((c < n/2) ? 2'b11 : 2'b00, tag);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Monitor: pops one expectation per input cycle and compares both halves
  initial begin
    logic hi, lo, have;
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      hi   = clk_o;
      have = (exp_q.size() > 0);
      if (have) e = exp_q.pop_front();
      #(CLK_PERIOD/2);
      lo = clk_o;
      if (have) begin
        checks++;
        if ({hi, lo} !== e.lvl) begin
          fails++;
          $display("FAIL %s: got %b expected %b at %0t", e.tag, {hi, lo}, e.lvl, $time);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Driver
  initial begin
    wait_cycles(2);
    check_now("R1", clk_o, 1'b0);
    wait_cycles(1);
    check_now("R1", clk_o, 1'b0);

    // R1/R2: reset release with default code 000
    rst_n = 1'b1;
    push_div(2, 1, "R1");
    push_div(2, 3, "R2");
    wait_cycles(8);

    // R3/R4: each ratio at period boundaries
    sel = 3'b001; push_div(3, 3, "R3"); wait_cycles(9);
    sel = 3'b010; push_div(4, 2, "R3"); wait_cycles(8);
    sel = 3'b011; push_div(5, 2, "R4"); wait_cycles(10);
    sel = 3'b100; push_div(6, 2, "R4"); wait_cycles(12);

    // R5: pass-through
    sel = 3'b110; push_rep(2'b10, 5, "R5"); wait_cycles(5);

    // R6: static code 101
    sel = 3'b101; push_rep(2'b00, 4, "R6"); wait_cycles(4);

    // R9: from static into divide-by-4
    sel = 3'b010; push_div(4, 2, "R9"); wait_cycles(8);

    // R6: static code 111
    sel = 3'b111; push_rep(2'b00, 3, "R6"); wait_cycles(3);

    // R8: change from /4 to /5 one cycle into a period
    sel = 3'b010; push(2'b11, "R9"); wait_cycles(1);
    sel = 3'b011;
    push(2'b11, "R8"); push(2'b00, "R8"); push(2'b00, "R8");
    push_div(5, 2, "R8");
    wait_cycles(13);

    // R7: power-down in the middle of a /6 period
    sel = 3'b100; push(2'b11, "R4"); push(2'b11, "R4"); wait_cycles(2);
    pd = 1'b1; push_rep(2'b00, 4, "R7"); wait_cycles(4);
    pd = 1'b0; push_div(6, 1, "R9"); wait_cycles(6);

    // R7: power-down during pass-through, then R9 restart at /2
    sel = 3'b110; push_rep(2'b10, 2, "R5"); wait_cycles(2);
    pd = 1'b1; push_rep(2'b00, 3, "R7"); wait_cycles(3);
    pd = 1'b0; sel = 3'b000; push_div(2, 2, "R9"); wait_cycles(4);

    // R9: from pass-through straight into /3
    sel = 3'b110; push_rep(2'b10, 2, "R5"); wait_cycles(2);
    sel = 3'b001; push_div(3, 2, "R9"); wait_cycles(6);

    wait_cycles(2);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4: got %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule